// File: doc/BRIEF.md
# Row/Bank Lane Crossbar

This block moves data sideways across a 64-lane wavefront. Every destination lane picks at most one source lane, and a 9-bit control code chooses the pattern. The wave is split into four rows of 16 lanes. Inside each row, four banks of 4 consecutive lanes are formed. The patterns are:

- a per-quad permute;
- mirrors over a row or a half row;
- two row broadcasts;
- single-lane shifts and rotates of the whole wave;
- row shifts and rotates by 1 to 15 lanes.

Two 4-bit enables, one per row and one per bank, decide which destination lanes may be written. A disabled lane keeps its old value.

A shift can ask a lane for data from beyond the edge of its row or of the wave. Such a source is invalid. A boundary control input decides what an invalid source produces: zero, or the lane's old value. The caller supplies all 64 source values, the 64 old destination values, the code and the masks on one strobe. The merged result appears one clock later, registered.

Top module: `lane_xbar`

## Requirements
- R1: While reset is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals `in_valid` one cycle later. `out_data` is updated only in a cycle in which `in_valid` is 1, and it holds otherwise.
- R3: Codes 0x000 to 0x0FF select a quad permute. Destination lane i reads lane 4*(i/4)+k, where k is code bits [2m+1:2m] and m = i mod 4.
- R4: Codes 0x100+n (row shift left) make lane i read lane i+n. Codes 0x110+n (row shift right) make lane i read lane i-n. In both cases n is 1 to 15, and the source is invalid when it falls outside the row of lane i.
- R5: Codes 0x120+n, with n from 1 to 15, select a row rotate right. Lane i reads the lane in its own row at position ((i mod 16) - n) mod 16.
- R6: The whole-wave codes are as follows:
  - 0x130: lane i reads lane i+1, and lane 63 is invalid.
  - 0x134: lane i reads lane (i+1) mod 64.
  - 0x138: lane i reads lane i-1, and lane 0 is invalid.
  - 0x13C: lane i reads lane (i+63) mod 64.
- R7: Code 0x140 mirrors each row: position p reads position 15-p. Code 0x141 mirrors each 8-lane half row: position p reads position 8*(p/8)+7-(p mod 8).
- R8: Code 0x142 writes lane 16r-1 to every lane of row r, for r from 1 to 3. Code 0x143 writes lane 31 to every lane of rows 2 and 3. The lanes these codes do not target keep their old value whatever the boundary control is.
- R9: An invalid source gives zero when `bound_ctrl` is 1. When `bound_ctrl` is 0, it gives the lane's old value.
- R10: `row_mask` bit r enables lanes 16r to 16r+15. `bank_mask` bit b enables lanes whose (i mod 16)/4 equals b. A lane with either bit 0 keeps its old value, even if its source is invalid and `bound_ctrl` is 1.
- R11: Every other code is reserved, including the row shift and row rotate codes with amount 0. A reserved code leaves every lane at its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures a new result |
| ctrl | input | 9 | Sharing pattern code |
| row_mask | input | 4 | Row write enables |
| bank_mask | input | 4 | Bank write enables |
| bound_ctrl | input | 1 | 1: invalid source gives zero; 0: lane keeps old value |
| src_data | input | 64*DW | Source lane values, lane i at bits [i*DW +: DW] |
| old_data | input | 64*DW | Previous destination lane values |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64*DW | Registered merged result |

## Verification
Write gating and the invalid-source rule can act on the same lane in the same cycle. This happens when a row shift or wave shift pushes a lane off an edge while that lane's row or bank is disabled. The bench provokes this case by issuing a shift-left-by-one with `bound_ctrl` set under sparse row and bank masks. Lanes at the row edges are therefore both invalid and, in some rows and banks, disabled. The bench judges the result against a lane-by-lane model in which the mask wins: a disabled edge lane must show its old value, not zero. The same model also covers the broadcast rows that are left untouched while `bound_ctrl` is 1.

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [8:0]         ctrl,
  input  logic [3:0]         row_mask,
  input  logic [3:0]         bank_mask,
  input  logic               bound_ctrl,
  input  logic [64*DW-1:0]   src_data,
  input  logic [64*DW-1:0]   old_data,
  output logic               out_valid,
  output logic [64*DW-1:0]   out_data
);
  localparam int LANES   = 64;
  localparam int ROWLEN  = 16;
  localparam int HALFLEN = ROWLEN / 2;
  localparam int BANKLEN = 4;
  localparam int IW      = $clog2(LANES);

  logic [LANES*DW-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int R = i / ROWLEN;
    localparam int P = i % ROWLEN;
    localparam int Q = i % BANKLEN;

    logic [IW-1:0] sel;
    logic          hit;
    logic          bad;
    int            s;
    int            a;

    always_comb begin
      s   = i;
      hit = 1'b0;
      bad = 1'b0;
      a   = int'(ctrl[3:0]);
      if (!ctrl[8]) begin
        hit = 1'b1;
        s   = i - Q + int'(ctrl[2*Q +: 2]);
      end else begin
        case (ctrl[7:4])
          4'h0: if (a != 0) begin
            hit = 1'b1;
            if (P + a > ROWLEN - 1) bad = 1'b1;
            else s = i + a;
          end
          4'h1: if (a != 0) begin
            hit = 1'b1;
            if (P < a) bad = 1'b1;
            else s = i - a;
          end
          4'h2: if (a != 0) begin
            hit = 1'b1;
            s   = R * ROWLEN + (P - a + ROWLEN) % ROWLEN;
          end
          4'h3: case (ctrl[3:0])
            4'h0: begin hit = 1'b1; if (i == LANES - 1) bad = 1'b1; else s = i + 1; end
            4'h4: begin hit = 1'b1; s = (i + 1) % LANES; end
            4'h8: begin hit = 1'b1; if (i == 0) bad = 1'b1; else s = i - 1; end
            4'hC: begin hit = 1'b1; s = (i + LANES - 1) % LANES; end
            default: ;
          endcase
          4'h4: case (ctrl[3:0])
            4'h0: begin hit = 1'b1; s = R * ROWLEN + ROWLEN - 1 - P; end
            4'h1: begin hit = 1'b1; s = R * ROWLEN + (P / HALFLEN) * HALFLEN + HALFLEN - 1 - P % HALFLEN; end
            4'h2: if (R >= 1) begin hit = 1'b1; s = R * ROWLEN - 1; end
            4'h3: if (R >= 2) begin hit = 1'b1; s = 2 * ROWLEN - 1; end
            default: ;
          endcase
          default: ;
        endcase
      end
      sel = IW'(s);
    end

    wire en = row_mask[R] & bank_mask[P / BANKLEN];

    assign nxt[i*DW +: DW] = (!en || !hit) ? old_data[i*DW +: DW] :
                             bad ? (bound_ctrl ? '0 : old_data[i*DW +: DW]) :
                             src_data[sel*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/lane_xbar_chk.sv
module lane_xbar_chk #(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [8:0]       ctrl,
  input logic [3:0]       row_mask,
  input logic [3:0]       bank_mask,
  input logic             bound_ctrl,
  input logic [64*DW-1:0] src_data,
  input logic [64*DW-1:0] old_data,
  input logic             out_valid,
  input logic [64*DW-1:0] out_data
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> out_valid == $past(in_valid));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(in_valid) |-> out_data == $past(out_data));

  assert_row_off_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(in_valid) && !$past(row_mask[0]) |->
      out_data[16*DW-1:0] == $past(old_data[16*DW-1:0]));

  assert_reserved_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(in_valid) && $past(ctrl) == 9'h1FF |-> out_data == $past(old_data));

  assert_mirror_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(in_valid && ctrl == 9'h140 && row_mask == 4'hF && bank_mask == 4'hF) |->
      out_data[DW-1:0] == $past(src_data[15*DW +: DW]));

  assert_edge_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(in_valid && ctrl == 9'h130 && bound_ctrl && row_mask[3] && bank_mask[3]) |->
      out_data[63*DW +: DW] == '0);
endmodule

bind lane_xbar lane_xbar_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
  .row_mask(row_mask), .bank_mask(bank_mask), .bound_ctrl(bound_ctrl),
  .src_data(src_data), .old_data(old_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/lane_xbar_test.sv
module lane_xbar_test;
  localparam int DW     = 16;
  localparam int PERIOD = 10;
  localparam int NV     = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [8:0]       ctrl = '0;
  logic [3:0]       row_mask = 4'hF;
  logic [3:0]       bank_mask = 4'hF;
  logic             bound_ctrl = 1'b0;
  logic [64*DW-1:0] src_data = '0;
  logic [64*DW-1:0] old_data = '0;
  logic             out_valid;
  logic [64*DW-1:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lane_xbar #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
    .row_mask(row_mask), .bank_mask(bank_mask), .bound_ctrl(bound_ctrl),
    .src_data(src_data), .old_data(old_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // code, row mask, bank mask, bound, requirement
  localparam logic [8:0] V_CODE [NV] = '{9'h0E4, 9'h01B, 9'h101, 9'h10F, 9'h113, 9'h125,
    9'h130, 9'h134, 9'h138, 9'h13C, 9'h140, 9'h141, 9'h142, 9'h143, 9'h101, 9'h100, 9'h1FF, 9'h0E4};
  localparam logic [3:0] V_RM [NV] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
    4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hA, 4'hF, 4'hF, 4'h0};
  localparam logic [3:0] V_BM [NV] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
    4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h6, 4'hF, 4'hF, 4'hF};
  localparam logic V_BC [NV] = '{0, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 1};
  // R3 R3 R4 R4 R4 R5 R6 R6 R6 R6 R7 R7 R8 R8 R10 R11 R11 R10 (R9 via bound column)
  localparam int V_REQ [NV] = '{3, 3, 4, 4, 4, 5, 6, 6, 6, 6, 7, 7, 8, 8, 10, 11, 11, 10};

  function automatic logic [DW-1:0] sv(int seed, int i);
    return DW'(16'h1000 + seed * 256 + i);
  endfunction
  function automatic logic [DW-1:0] ov(int seed, int i);
    return DW'(16'h8000 + seed * 256 + i);
  endfunction

  // kind: 0 copy src[s], 1 invalid source, 2 untouched
  function automatic logic [DW-1:0] model(int i, logic [8:0] c, logic [3:0] rm, logic [3:0] bm,
                                          logic bc, int seed);
    int r = i / 16, p = i % 16, n = int'(c[3:0]), s = 0, kind = 2;
    if (!rm[r] || !bm[p / 4]) return ov(seed, i);
    if (c < 9'h100) begin kind = 0; s = 4 * (i / 4) + int'(c[2 * (i % 4) +: 2]); end
    else if (c[8:4] == 5'h10 && n > 0) begin kind = (p + n > 15) ? 1 : 0; s = i + n; end
    else if (c[8:4] == 5'h11 && n > 0) begin kind = (p - n < 0) ? 1 : 0; s = i - n; end
    else if (c[8:4] == 5'h12 && n > 0) begin kind = 0; s = 16 * r + ((p + 16 - n) % 16); end
    else if (c == 9'h130) begin kind = (i == 63) ? 1 : 0; s = i + 1; end
    else if (c == 9'h134) begin kind = 0; s = (i + 1) % 64; end
    else if (c == 9'h138) begin kind = (i == 0) ? 1 : 0; s = i - 1; end
    else if (c == 9'h13C) begin kind = 0; s = (i + 63) % 64; end
    else if (c == 9'h140) begin kind = 0; s = 16 * r + 15 - p; end
    else if (c == 9'h141) begin kind = 0; s = i - (p % 8) + 7 - (p % 8); end
    else if (c == 9'h142 && r > 0) begin kind = 0; s = 16 * r - 1; end
    else if (c == 9'h143 && r > 1) begin kind = 0; s = 31; end
    if (kind == 2) return ov(seed, i);
    if (kind == 1) return bc ? '0 : ov(seed, i);
    return sv(seed, s);
  endfunction

  task automatic run_vec(int k);
    int seed = k % 13;
    for (int i = 0; i < 64; i++) begin
      src_data[i*DW +: DW] = sv(seed, i);
      old_data[i*DW +: DW] = ov(seed, i);
    end
    @(negedge clk);
    ctrl = V_CODE[k]; row_mask = V_RM[k]; bank_mask = V_BM[k]; bound_ctrl = V_BC[k];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    tests++;
    begin
      int bad = -1;
      logic [DW-1:0] e = '0;
      for (int i = 0; i < 64; i++) begin
        logic [DW-1:0] m = model(i, V_CODE[k], V_RM[k], V_BM[k], V_BC[k], seed);
        if (bad < 0 && out_data[i*DW +: DW] !== m) begin bad = i; e = m; end
      end
      if (!out_valid || bad >= 0) begin
        fails++;
        if (bad < 0) bad = 0;
        $display("FAIL R%0d vec %0d code %h lane %0d valid %b: got %h expected %h",
                 V_REQ[k], k, V_CODE[k], bad, out_valid, out_data[bad*DW +: DW], e);
      end
    end
  endtask

  initial begin
    logic [64*DW-1:0] snap;
    #(PERIOD * 3);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1 reset state: valid %b data %h expected 0 0", out_valid, out_data[DW-1:0]);
    end
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) run_vec(k);

    // R2: idle cycles with changed inputs do not disturb the output
    snap = out_data;
    ctrl = 9'h134; old_data = ~old_data; src_data = ~src_data;
    @(negedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_data !== snap) begin
      fails++;
      $display("FAIL R2 idle hold: valid %b lane0 %h expected 0 %h", out_valid, out_data[DW-1:0], snap[DW-1:0]);
    end

    // R9: bound off, wave shift right keeps lane 0 old
    run_vec(8);
    tests++;
    if (out_data[DW-1:0] !== ov(8, 0)) begin
      fails++;
      $display("FAIL R9 lane0 got %h expected %h", out_data[DW-1:0], ov(8, 0));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule